// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is a serial slave that holds the configuration registers of a dual-channel converter datapath. An external controller reaches it over a serial clock, an active-low select and either a shared bidirectional data pin (3-wire) or a separate input and output pin (4-wire). The pins are sampled by the block's own system clock through synchronizers, so the serial clock is never used as a clock inside the block. The pin directions are brought out as separate input, output and enable signals; the pad ring merges them.

Every transaction starts with one instruction byte followed by one to four data bytes. The instruction byte's bit 7 is the direction (1 read, 0 write), bits 6:5 give the byte count minus one and bits 4:0 give the start address. The address advances by one after each data byte. The stored fields drive the datapath continuously: input mode, input coding, a 32-bit oscillator frequency word, a 16-bit oscillator phase and two general configuration bytes. A write to the control register can restore every other register to its default.

Top module: `spi_cfg_bank`

## Requirements
- R1: Hardware reset (rstN low, asynchronous) loads every register, the control register 00h included, with its default: 02h resets to 0x10 and all other registers to 0x00.
- R2: Serial data is taken on the rising edge of the serial clock, most significant bit first. The instruction byte has the direction in bit 7 (1 = read), the byte count minus one in bits 6:5 and the start address in bits 4:0.
- R3: The address increments after each data byte. Once the number of data bytes given in the instruction has been transferred, further bits in the same transaction are ignored.
- R4: Registers 03h..06h hold the frequency word, with 03h the least significant byte; ncoFreq shows {06h,05h,04h,03h}.
- R5: Registers 07h (low) and 08h (high) hold the phase; ncoPhase shows {08h,07h}.
- R6: Control register bit 3 drives inMode and bit 2 drives coding.
- R7: Read data leaves the block MSB first. Each new bit is shifted out on a falling edge of the serial clock, so it is valid at the following rising edge. In 4-wire mode the bits appear on sdoOut with sdoOe high only during the data bytes of a read.
- R8: Control register bit 7 set to 1 selects 3-wire mode. Input bits are then taken from sdioIn, read data is driven on sdioOut with sdioOe, and sdoOe stays low. sdoOe and sdioOe are never high together.
- R9: Writing the control register with bit 6 set restores registers 01h..08h to their defaults in the same cycle. The control register takes the other written bits. Bit 6 reads back as 0.
- R10: Raising the select before a byte completes discards that partial byte with no register change. The next transaction starts again with an instruction byte.
- R11: Addresses 09h..1Fh read as 0x00, and writes to them change nothing.
- R12: Registers 01h and 02h are readable and writable and appear on cfgA and cfgB.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| sclk | input | 1 | Serial clock |
| csN | input | 1 | Active-low select |
| sdiIn | input | 1 | Serial data input in 4-wire mode |
| sdioIn | input | 1 | Input side of the shared data pin (3-wire) |
| sdoOut | output | 1 | Serial data output in 4-wire mode |
| sdoOe | output | 1 | Drive enable for sdoOut |
| sdioOut | output | 1 | Output side of the shared data pin |
| sdioOe | output | 1 | Drive enable for the shared data pin |
| inMode | output | 1 | Input mode select (0 dual-port, 1 interleaved) |
| coding | output | 1 | Input coding select (control bit 2) |
| ncoFreq | output | 32 | Oscillator frequency word |
| ncoPhase | output | 16 | Oscillator phase word |
| cfgA | output | 8 | Contents of register 01h |
| cfgB | output | 8 | Contents of register 02h |

## Verification
The software reset and the ordinary write of the control register fall in the same cycle, because the restore is triggered by the very byte that updates 00h. The bench provokes this by loading non-default frequency, phase and configuration values and then writing 0x4C to 00h. It judges the outcome at the ports: inMode and coding must both show 1, while ncoFreq, ncoPhase, cfgA and cfgB must be back at their defaults. A read of 00h must then return 0x0C. A second overlap is tested as well: the write that sets bit 7 changes the data pin for the next transaction, so a 3-wire write and read with the 4-wire input held low must still return the written byte.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;

  localparam int REG_CTRL     = 0;
  localparam int REG_CFG_A    = 1;
  localparam int REG_CFG_B    = 2;
  localparam int REG_FREQ_0   = 3;
  localparam int REG_PHASE_LO = 7;
  localparam int REG_PHASE_HI = 8;
  localparam int NUM_REGS     = REG_PHASE_HI + 1;

  localparam int BIT_THREE_WIRE = 7;
  localparam int BIT_SOFT_RST   = 6;
  localparam int BIT_IN_MODE    = 3;
  localparam int BIT_CODING     = 2;

  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic [DATA_W-1:0] wrData;
  } cfg_strobe_t;

  function automatic logic [DATA_W-1:0] regDefault(input int idx);
    return (idx == REG_CFG_B) ? DATA_W'(8'h10) : '0;
  endfunction

endpackage

// File: rtl/spi_cfg_ctrl.sv
module spi_cfg_ctrl
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              csN,
  input  logic              sdiIn,
  input  logic              sdioIn,
  input  logic              threeWire,
  input  logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] rdAddr,
  output cfg_strobe_t       strb,
  output logic              txBit,
  output logic              txActive
);

  localparam int CNT_W = $clog2(DATA_W);

  typedef enum logic [1:0] {ST_INSTR, ST_DATA, ST_DONE} ctrl_state_t;

  logic [SYNC_STAGES:0] sclkPipe, csPipe, sdiPipe, sdioPipe;
  logic sclkRise, sclkFall, csActive, dataBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPipe <= '0;
      csPipe   <= '1;
      sdiPipe  <= '0;
      sdioPipe <= '0;
    end else begin
      sclkPipe <= {sclkPipe[SYNC_STAGES-1:0], sclk};
      csPipe   <= {csPipe[SYNC_STAGES-1:0], csN};
      sdiPipe  <= {sdiPipe[SYNC_STAGES-1:0], sdiIn};
      sdioPipe <= {sdioPipe[SYNC_STAGES-1:0], sdioIn};
    end
  end

  assign sclkRise = sclkPipe[SYNC_STAGES-1] & ~sclkPipe[SYNC_STAGES];
  assign sclkFall = ~sclkPipe[SYNC_STAGES-1] & sclkPipe[SYNC_STAGES];
  assign csActive = ~csPipe[SYNC_STAGES-1];
  assign dataBit  = threeWire ? sdioPipe[SYNC_STAGES-1] : sdiPipe[SYNC_STAGES-1];

  ctrl_state_t       state;
  logic [DATA_W-2:0] rxShift;
  logic [CNT_W-1:0]  bitCnt;
  logic              isRead;
  logic [1:0]        bytesLeft;
  logic [ADDR_W-1:0] curAddr;
  logic [DATA_W-1:0] txShift;
  logic              txFresh;
  logic [DATA_W-1:0] rxByte;
  logic              byteDone;

  assign rxByte   = {rxShift, dataBit};
  assign byteDone = csActive && sclkRise && (bitCnt == CNT_W'(DATA_W - 1)) && (state != ST_DONE);
  assign rdAddr   = (state == ST_INSTR) ? rxByte[ADDR_W-1:0] : curAddr + ADDR_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_INSTR;
      rxShift   <= '0;
      bitCnt    <= '0;
      isRead    <= 1'b0;
      bytesLeft <= '0;
      curAddr   <= '0;
      txShift   <= '0;
      txFresh   <= 1'b0;
    end else if (!csActive) begin
      state   <= ST_INSTR;
      bitCnt  <= '0;
      isRead  <= 1'b0;
      txFresh <= 1'b0;
    end else if (sclkRise && state != ST_DONE) begin
      rxShift <= rxByte[DATA_W-2:0];
      bitCnt  <= bitCnt + CNT_W'(1);
      if (byteDone) begin
        case (state)
          ST_INSTR: begin
            isRead    <= rxByte[7];
            bytesLeft <= rxByte[6:5];
            curAddr   <= rxByte[ADDR_W-1:0];
            state     <= ST_DATA;
            if (rxByte[7]) begin
              txShift <= rdData;
              txFresh <= 1'b1;
            end
          end
          default: begin
            curAddr <= curAddr + ADDR_W'(1);
            if (bytesLeft == 2'd0) begin
              state <= ST_DONE;
            end else begin
              bytesLeft <= bytesLeft - 2'd1;
              if (isRead) begin
                txShift <= rdData;
                txFresh <= 1'b1;
              end
            end
          end
        endcase
      end
    end else if (sclkFall && state == ST_DATA && isRead) begin
      if (txFresh) txFresh <= 1'b0;
      else         txShift <= {txShift[DATA_W-2:0], 1'b0};
    end
  end

  always_comb begin
    strb.wrEn   = byteDone && (state == ST_DATA) && !isRead;
    strb.wrAddr = curAddr;
    strb.wrData = rxByte;
  end

  assign txBit    = txShift[DATA_W-1];
  assign txActive = csActive && (state == ST_DATA) && isRead;

  // R3: one data byte yields at most one write strobe
  a_r3_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrEn |=> !strb.wrEn);

  // R10: a new select window always starts at a byte boundary in the instruction phase
  a_r10_fresh_start: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csActive) |-> (bitCnt == '0) && (state == ST_INSTR));

endmodule

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  cfg_strobe_t       strb,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic              threeWire,
  output logic              inMode,
  output logic              coding,
  output logic [31:0]       ncoFreq,
  output logic [15:0]       ncoPhase,
  output logic [7:0]        cfgA,
  output logic [7:0]        cfgB
);

  logic [DATA_W-1:0] regFile [NUM_REGS];
  logic ctrlWrite, softRst;

  assign ctrlWrite = strb.wrEn && (strb.wrAddr == ADDR_W'(REG_CTRL));
  assign softRst   = ctrlWrite && strb.wrData[BIT_SOFT_RST];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          regFile[REG_CTRL] <= regDefault(REG_CTRL);
    else if (ctrlWrite) regFile[REG_CTRL] <= strb.wrData & ~(DATA_W'(1) << BIT_SOFT_RST);
  end

  for (genvar g = 1; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)        regFile[g] <= regDefault(g);
      else if (softRst) regFile[g] <= regDefault(g);
      else if (strb.wrEn && strb.wrAddr == ADDR_W'(g)) regFile[g] <= strb.wrData;
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rdAddr == ADDR_W'(i)) rdData = regFile[i];
    end
  end

  assign threeWire = regFile[REG_CTRL][BIT_THREE_WIRE];
  assign inMode    = regFile[REG_CTRL][BIT_IN_MODE];
  assign coding    = regFile[REG_CTRL][BIT_CODING];
  assign ncoFreq   = {regFile[REG_FREQ_0+3], regFile[REG_FREQ_0+2],
                      regFile[REG_FREQ_0+1], regFile[REG_FREQ_0]};
  assign ncoPhase  = {regFile[REG_PHASE_HI], regFile[REG_PHASE_LO]};
  assign cfgA      = regFile[REG_CFG_A];
  assign cfgB      = regFile[REG_CFG_B];

  // R9: soft reset restores the datapath fields
  a_r9_soft_restore: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == ADDR_W'(REG_CTRL) && strb.wrData[BIT_SOFT_RST])
    |=> (ncoFreq == '0) && (ncoPhase == '0) && (cfgA == 8'h00) && (cfgB == 8'h10));

  // R9: the control register keeps the bits written alongside the soft reset
  a_r9_ctrl_kept: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == ADDR_W'(REG_CTRL))
    |=> (threeWire == $past(strb.wrData[BIT_THREE_WIRE])) && (coding == $past(strb.wrData[BIT_CODING])));

  // R4: register 03h lands in the least significant byte of the frequency word
  a_r4_freq_low_byte: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr == ADDR_W'(REG_FREQ_0)) |=> ncoFreq[7:0] == $past(strb.wrData));

  // R11: writes beyond the map leave every field alone
  a_r11_unmapped_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrEn && strb.wrAddr >= ADDR_W'(NUM_REGS))
    |=> $stable(ncoFreq) && $stable(ncoPhase) && $stable(cfgA) && $stable(cfgB));

endmodule

// File: rtl/spi_cfg_bank.sv
module spi_cfg_bank
  import spi_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        sclk,
  input  logic        csN,
  input  logic        sdiIn,
  input  logic        sdioIn,
  output logic        sdoOut,
  output logic        sdoOe,
  output logic        sdioOut,
  output logic        sdioOe,
  output logic        inMode,
  output logic        coding,
  output logic [31:0] ncoFreq,
  output logic [15:0] ncoPhase,
  output logic [7:0]  cfgA,
  output logic [7:0]  cfgB
);

  cfg_strobe_t       strb;
  logic [ADDR_W-1:0] rdAddr;
  logic [DATA_W-1:0] rdData;
  logic threeWire, txBit, txActive;

  spi_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN),
    .sdiIn(sdiIn), .sdioIn(sdioIn), .threeWire(threeWire),
    .rdData(rdData), .rdAddr(rdAddr), .strb(strb),
    .txBit(txBit), .txActive(txActive)
  );

  spi_cfg_regs u_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .rdAddr(rdAddr), .rdData(rdData),
    .threeWire(threeWire), .inMode(inMode), .coding(coding),
    .ncoFreq(ncoFreq), .ncoPhase(ncoPhase), .cfgA(cfgA), .cfgB(cfgB)
  );

  assign sdoOut  = txBit;
  assign sdioOut = txBit;
  assign sdoOe   = txActive & ~threeWire;
  assign sdioOe  = txActive & threeWire;

  // R8: the two data outputs never drive at once
  a_r8_one_driver: assert property (@(posedge clk) disable iff (!rstN)
    !(sdoOe && sdioOe));

endmodule

// File: tb/tb_spi_cfg_bank.sv
module tb_spi_cfg_bank;

  localparam int HALF = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, csN = 1'b1, sdiIn = 1'b0, sdioIn = 1'b0;
  logic sdoOut, sdoOe, sdioOut, sdioOe, inMode, coding;
  logic [31:0] ncoFreq;
  logic [15:0] ncoPhase;
  logic [7:0]  cfgA, cfgB;

  always #4 clk = ~clk;

  spi_cfg_bank dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdiIn(sdiIn), .sdioIn(sdioIn),
    .sdoOut(sdoOut), .sdoOe(sdoOe), .sdioOut(sdioOut), .sdioOe(sdioOe),
    .inMode(inMode), .coding(coding), .ncoFreq(ncoFreq), .ncoPhase(ncoPhase),
    .cfgA(cfgA), .cfgB(cfgB)
  );

  int checks = 0, fails = 0;
  bit finished = 1'b0;
  bit threeMode = 1'b0;
  bit sawSdoOe, sawSdioOe;

  // addr, write data, expected read-back (R12, R4, R5, R11)
  localparam logic [23:0] VEC [8] = '{
    {8'h01, 8'h3C, 8'h3C}, {8'h02, 8'h81, 8'h81}, {8'h03, 8'h11, 8'h11},
    {8'h06, 8'hF0, 8'hF0}, {8'h07, 8'h5A, 8'h5A}, {8'h08, 8'hC3, 8'hC3},
    {8'h0C, 8'h55, 8'h00}, {8'h1F, 8'hAA, 8'h00}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic spiBit(input logic b, output logic r);
    if (threeMode) sdioIn = b; else sdiIn = b;
    waitClk(HALF);
    r = threeMode ? sdioOut : sdoOut;
    if (sdoOe) sawSdoOe = 1'b1;
    if (sdioOe) sawSdioOe = 1'b1;
    sclk = 1'b1;
    waitClk(HALF);
    sclk = 1'b0;
  endtask

  task automatic spiByte(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) spiBit(tx[i], rx[i]);
  endtask

  task automatic csStart();
    sawSdoOe = 1'b0;
    sawSdioOe = 1'b0;
    csN = 1'b0;
    waitClk(HALF);
  endtask

  task automatic csEnd();
    waitClk(HALF);
    csN = 1'b1;
    waitClk(2 * HALF + 4);
  endtask

  // n bytes (1..4), byte k taken from data[8k+:8]
  task automatic spiWrite(input logic [4:0] addr, input int n, input logic [31:0] data);
    logic [7:0] junk;
    csStart();
    spiByte({1'b0, 2'(n - 1), addr}, junk);
    for (int k = 0; k < n; k++) spiByte(data[8*k +: 8], junk);
    csEnd();
  endtask

  task automatic spiRead(input logic [4:0] addr, input int n, output logic [31:0] data);
    logic [7:0] rx;
    data = '0;
    csStart();
    spiByte({1'b1, 2'(n - 1), addr}, rx);
    for (int k = 0; k < n; k++) begin
      spiByte(8'h00, rx);
      data[8*k +: 8] = rx;
    end
    csEnd();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0] junk, saveB;
    waitClk(5);
    rstN = 1'b1;
    waitClk(5);

    // R1: reset state
    check("R1 freq", ncoFreq, 32'h0);
    check("R1 cfgB", {24'h0, cfgB}, 32'h10);
    check("R1 inMode", {31'h0, inMode}, 32'h0);
    check("R7 idle oe", {30'h0, sdoOe, sdioOe}, 32'h0);
    spiRead(5'h02, 1, rd);
    check("R1 read 02h", rd, 32'h10);

    // table: single-byte write then read-back (R2, R12, R11)
    for (int v = 0; v < 8; v++) begin
      spiWrite(VEC[v][20:16], 1, {24'h0, VEC[v][15:8]});
      spiRead(VEC[v][20:16], 1, rd);
      check("R2/R12/R11 vector", rd, {24'h0, VEC[v][7:0]});
    end
    check("R12 cfgA", {24'h0, cfgA}, 32'h3C);
    check("R5 phase from table", {16'h0, ncoPhase}, 32'hC35A);

    // R4 / R3: multi-byte write, LSB first
    spiWrite(5'h03, 4, 32'h12345678);
    check("R4 freq word", ncoFreq, 32'h12345678);
    spiWrite(5'h07, 2, 32'h0000ABCD);
    check("R5 phase word", {16'h0, ncoPhase}, 32'hABCD);

    // R7: 4-byte read on the 4-wire output
    spiRead(5'h03, 4, rd);
    check("R7 burst read", rd, 32'h12345678);
    check("R7 sdoOe seen", {31'h0, sawSdoOe}, 32'h1);
    check("R8 sdioOe quiet in 4-wire", {31'h0, sawSdioOe}, 32'h0);

    // R6: control bits
    spiWrite(5'h00, 1, 32'h0C);
    check("R6 mode+coding", {30'h0, inMode, coding}, 32'h3);
    spiWrite(5'h00, 1, 32'h04);
    check("R6 coding only", {30'h0, inMode, coding}, 32'h1);

    // R3: extra byte beyond count ignored
    saveB = cfgB;
    csStart();
    spiByte({1'b0, 2'd0, 5'h01}, junk);
    spiByte(8'h11, junk);
    spiByte(8'h22, junk);
    csEnd();
    check("R3 counted byte", {24'h0, cfgA}, 32'h11);
    check("R3 extra ignored", {24'h0, cfgB}, {24'h0, saveB});

    // R10: partial byte aborted
    csStart();
    spiByte({1'b0, 2'd0, 5'h01}, junk);
    for (int i = 0; i < 5; i++) spiBit(1'b1, junk[0]);
    csEnd();
    check("R10 abort keeps cfgA", {24'h0, cfgA}, 32'h11);
    spiWrite(5'h01, 1, 32'h77);
    check("R10 next transaction", {24'h0, cfgA}, 32'h77);

    // R9: soft reset and control write in the same cycle
    spiWrite(5'h00, 1, 32'h4C);
    check("R9 ctrl bits kept", {30'h0, inMode, coding}, 32'h3);
    check("R9 freq default", ncoFreq, 32'h0);
    check("R9 phase default", {16'h0, ncoPhase}, 32'h0);
    check("R9 cfg defaults", {16'h0, cfgA, cfgB}, 32'h0010);
    spiRead(5'h00, 1, rd);
    check("R9 ctrl readback", rd, 32'h0C);

    // R8: switch to 3-wire
    spiWrite(5'h00, 1, 32'h80);
    threeMode = 1'b1;
    sdiIn = 1'b0;
    spiWrite(5'h07, 1, 32'h99);
    check("R8 3-wire write", {16'h0, ncoPhase}, 32'h0099);
    spiRead(5'h07, 1, rd);
    check("R8 3-wire read", rd, 32'h99);
    check("R8 sdioOe seen", {31'h0, sawSdioOe}, 32'h1);
    check("R8 sdoOe quiet", {31'h0, sawSdoOe}, 32'h0);

    // R1: hardware reset clears 00h as well
    rstN = 1'b0;
    waitClk(3);
    rstN = 1'b1;
    threeMode = 1'b0;
    waitClk(3);
    spiRead(5'h00, 1, rd);
    check("R1 ctrl after hw reset", rd, 32'h00);
    check("R1 phase after hw reset", {16'h0, ncoPhase}, 32'h0);
    check("R1 cfgB after hw reset", {24'h0, cfgB}, 32'h10);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule